// File: doc/BRIEF.md
# Drive Control and Soft Reset Register Block

This block is the host-facing control register of a legacy disk controller. A byte written to its output register sets four per-drive motor enables, a gate for the interrupt and DMA request lines, a level-held soft reset bit and a two-bit drive select. A second write-only rate register shares a two-bit transfer-rate field with a configuration-control register. Bit 7 of the rate register starts a reset pulse that times itself out after a fixed number of clock cycles.

While either reset source is active, the block asserts an internal reset to the rest of the controller. During that reset it clears the stored drive timing values and the non-DMA flag. It also clears the FIFO enable and the threshold, unless the configuration has been locked. When the reset ends, the block raises the interrupt. With drive polling on, it also queues one status byte per drive, and the command logic pops these one at a time with a sense handshake. The command logic writes configuration, lock and timing values through simple load strobes.

Top module: `drvctl_reset_unit`

## Requirements
- R1: A write with `wr_addr`=0 stores `wr_data` in the output register. `ctl_rdata` reads it back, and its value after `rst_n` is 0x00. `motor_en[i]` follows bit 4+i, `drv_sel` follows bits 1:0, and bit 3 is the request gate.
- R2: `core_rst` is high in every cycle in which output register bit 2 is 0, including the cycles after power-up.
- R3: A write with `wr_addr`=1 and `wr_data[7]`=1 holds `core_rst` high for exactly PULSE_CYC cycles after the write edge, and the reset then ends with no further write.
- R4: `rate_sel` takes `wr_data[1:0]` on a write with `wr_addr`=1 or `wr_addr`=2. No reset changes it, and `wr_addr`=3 is ignored.
- R5: One cycle after `core_rst` falls, if `poll_en` is 1, NUM_DRV status entries are queued. `sense_st0` shows 0xC0|d for drive d = 0,1,2,3 in order, each `sense_ack` removes the head entry, and `sense_st0` shows 0x80 when nothing is queued.
- R6: With `poll_en` at 0, leaving reset sets one pending interrupt with no entries, and `sense_ack` clears it.
- R7: `irq` equals (pending entry or flag) AND output register bit 3 AND NOT `core_rst`. Masked entries stay queued. `dma_req` equals `dma_req_in` AND bit 3 AND NOT `core_rst`.
- R8: During `core_rst`, `fifo_en` and `fifo_thr` clear to 0 unless `lock_q` is 1. `poll_en` and `iseek_en` are never changed by reset.
- R9: During `core_rst`, `step_rate`, `unload_time`, `load_time` and `non_dma` clear to 0.
- R10: `cfg_load`, `lock_load`, `spec_load` and `sense_ack` have no effect in a cycle where `core_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | 0 output reg, 1 rate reg, 2 config-control reg, 3 unused |
| wr_data | input | 8 | Host write data |
| ctl_rdata | output | 8 | Output register readback |
| motor_en | output | NUM_DRV | Per-drive motor enables |
| drv_sel | output | 2 | Selected drive |
| rate_sel | output | 2 | Transfer-rate code (0 500k, 1 300k, 2 250k, 3 1M) |
| core_rst | output | 1 | Internal reset to the controller |
| dma_req_in | input | 1 | Raw DMA request from the data path |
| dma_req | output | 1 | Gated DMA request |
| irq | output | 1 | Gated interrupt request |
| sense_ack | input | 1 | Pop one interrupt status |
| sense_st0 | output | 8 | Head status byte, 0x80 when none |
| cfg_load | input | 1 | Load configuration fields |
| cfg_fifo_en_in | input | 1 | New FIFO enable |
| cfg_thr_in | input | THR_W | New FIFO threshold |
| cfg_poll_in | input | 1 | New drive polling enable |
| cfg_iseek_in | input | 1 | New implied-seek enable |
| lock_load | input | 1 | Load lock flag |
| lock_in | input | 1 | New lock flag |
| spec_load | input | 1 | Load drive timing fields |
| spec_srt_in | input | SRT_W | New step rate |
| spec_hut_in | input | HUT_W | New head unload time |
| spec_hlt_in | input | HLT_W | New head load time |
| spec_nodma_in | input | 1 | New non-DMA flag |
| fifo_en | output | 1 | FIFO enable |
| fifo_thr | output | THR_W | FIFO threshold |
| poll_en | output | 1 | Drive polling enable |
| iseek_en | output | 1 | Implied-seek enable |
| lock_q | output | 1 | Lock flag |
| step_rate | output | SRT_W | Step rate |
| unload_time | output | HUT_W | Head unload time |
| load_time | output | HLT_W | Head load time |
| non_dma | output | 1 | Non-DMA flag |

## Verification
A wrong pulse counter appears on `core_rst` at the first cycle it differs from the programmed length. A mistimed edge detector shows up the next cycle as an early or missing `irq`. A queue pointer or count fault shows up at the next `sense_ack`, as a wrong `sense_st0` byte or an entry too many or too few. Because every output is compared every clock, a lock or timing-field clearing fault appears on the first cycle after `core_rst` starts.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;
   typedef enum logic [1:0] {
      ADDR_CTL  = 2'd0,
      ADDR_RATE = 2'd1,
      ADDR_CCR  = 2'd2,
      ADDR_NONE = 2'd3
   } drvctl_addr_e;

   localparam int CTL_MOT_LSB = 4;
   localparam int CTL_GATE    = 3;
   localparam int CTL_RUN     = 2;
   localparam int RATE_PULSE  = 7;
   localparam logic [7:0] ST0_POLL_BASE = 8'hC0;
   localparam logic [7:0] ST0_NONE      = 8'h80;
endpackage

// File: rtl/drvctl_pulse.sv
module drvctl_pulse #(
   parameter int PULSE_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(PULSE_CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (start)    cnt <= CW'(PULSE_CYC);
      else if (cnt != 0) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1) && !start) |=> !busy);
endmodule

// File: rtl/drvctl_pollq.sv
module drvctl_pollq
   import drvctl_pkg::*;
#(
   parameter int NUM_DRV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_rst,
   input  logic       poll_en,
   input  logic       sense_ack,
   output logic       pending,
   output logic [7:0] st0
);
   localparam int QW = $clog2(NUM_DRV + 1);
   logic [QW-1:0] qcnt;
   logic [1:0]    qdrv;
   logic          flag;
   logic          prst;
   logic          leave;

   assign leave = prst && !in_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt <= '0; qdrv <= '0; flag <= 1'b0; prst <= 1'b1;
      end else begin
         prst <= in_rst;
         if (in_rst) begin
            qcnt <= '0; flag <= 1'b0;
         end else if (leave) begin
            if (poll_en) begin
               qcnt <= QW'(NUM_DRV); qdrv <= '0;
            end else begin
               flag <= 1'b1;
            end
         end else if (sense_ack) begin
            flag <= 1'b0;
            if (qcnt != '0) begin
               qcnt <= qcnt - 1'b1;
               qdrv <= qdrv + 1'b1;
            end
         end
      end
   end

   assign pending = (qcnt != '0) || flag;
   assign st0     = (qcnt != '0) ? (ST0_POLL_BASE | {6'd0, qdrv}) : ST0_NONE;

   p_qcnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      qcnt <= QW'(NUM_DRV));
   p_exit_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (leave && poll_en) |=> (qcnt == QW'(NUM_DRV) && qdrv == 2'd0));
   p_rst_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_rst |=> !pending);
   p_flag_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (leave && !poll_en) |=> (pending && st0 == ST0_NONE));
endmodule

// File: rtl/drvctl_cfg.sv
module drvctl_cfg #(
   parameter int THR_W = 4,
   parameter int SRT_W = 4,
   parameter int HUT_W = 4,
   parameter int HLT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_rst,
   input  logic             cfg_load,
   input  logic             cfg_fifo_en_in,
   input  logic [THR_W-1:0] cfg_thr_in,
   input  logic             cfg_poll_in,
   input  logic             cfg_iseek_in,
   input  logic             lock_load,
   input  logic             lock_in,
   input  logic             spec_load,
   input  logic [SRT_W-1:0] spec_srt_in,
   input  logic [HUT_W-1:0] spec_hut_in,
   input  logic [HLT_W-1:0] spec_hlt_in,
   input  logic             spec_nodma_in,
   output logic             fifo_en,
   output logic [THR_W-1:0] fifo_thr,
   output logic             poll_en,
   output logic             iseek_en,
   output logic             lock_q,
   output logic [SRT_W-1:0] step_rate,
   output logic [HUT_W-1:0] unload_time,
   output logic [HLT_W-1:0] load_time,
   output logic             non_dma
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en <= 1'b0; fifo_thr <= '0; poll_en <= 1'b1;
         iseek_en <= 1'b0; lock_q <= 1'b0;
      end else if (in_rst) begin
         if (!lock_q) begin
            fifo_en  <= 1'b0;
            fifo_thr <= '0;
         end
      end else begin
         if (cfg_load) begin
            fifo_en  <= cfg_fifo_en_in;
            fifo_thr <= cfg_thr_in;
            poll_en  <= cfg_poll_in;
            iseek_en <= cfg_iseek_in;
         end
         if (lock_load) lock_q <= lock_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || in_rst) begin
         step_rate <= '0; unload_time <= '0; load_time <= '0; non_dma <= 1'b0;
      end else if (spec_load) begin
         step_rate   <= spec_srt_in;
         unload_time <= spec_hut_in;
         load_time   <= spec_hlt_in;
         non_dma     <= spec_nodma_in;
      end
   end

   p_lock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rst && lock_q) |=> ($stable(fifo_en) && $stable(fifo_thr)));
   p_unlock_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rst && !lock_q) |=> (!fifo_en && fifo_thr == '0));
   p_keep_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_rst |=> ($stable(poll_en) && $stable(iseek_en) && $stable(lock_q)));
   p_timing_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_rst |=> (step_rate == '0 && unload_time == '0 && load_time == '0 && !non_dma));
endmodule

// File: rtl/drvctl_reset_unit.sv
module drvctl_reset_unit
   import drvctl_pkg::*;
#(
   parameter int NUM_DRV   = 4,
   parameter int PULSE_CYC = 1000,
   parameter int THR_W     = 4,
   parameter int SRT_W     = 4,
   parameter int HUT_W     = 4,
   parameter int HLT_W     = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [7:0]         wr_data,
   output logic [7:0]         ctl_rdata,
   output logic [NUM_DRV-1:0] motor_en,
   output logic [1:0]         drv_sel,
   output logic [1:0]         rate_sel,
   output logic               core_rst,
   input  logic               dma_req_in,
   output logic               dma_req,
   output logic               irq,
   input  logic               sense_ack,
   output logic [7:0]         sense_st0,
   input  logic               cfg_load,
   input  logic               cfg_fifo_en_in,
   input  logic [THR_W-1:0]   cfg_thr_in,
   input  logic               cfg_poll_in,
   input  logic               cfg_iseek_in,
   input  logic               lock_load,
   input  logic               lock_in,
   input  logic               spec_load,
   input  logic [SRT_W-1:0]   spec_srt_in,
   input  logic [HUT_W-1:0]   spec_hut_in,
   input  logic [HLT_W-1:0]   spec_hlt_in,
   input  logic               spec_nodma_in,
   output logic               fifo_en,
   output logic [THR_W-1:0]   fifo_thr,
   output logic               poll_en,
   output logic               iseek_en,
   output logic               lock_q,
   output logic [SRT_W-1:0]   step_rate,
   output logic [HUT_W-1:0]   unload_time,
   output logic [HLT_W-1:0]   load_time,
   output logic               non_dma
);
   initial begin
      assert (NUM_DRV >= 1 && NUM_DRV <= 4) else $error("NUM_DRV must be 1..4");
      assert (PULSE_CYC >= 1) else $error("PULSE_CYC must be positive");
      assert (THR_W >= 1 && SRT_W >= 1 && HUT_W >= 1 && HLT_W >= 1)
         else $error("field widths must be positive");
   end

   logic [7:0] ctl_q;
   logic [1:0] rate_q;
   logic       wr_ctl, wr_rate, wr_ccr, pulse_go, pulse_busy;
   logic       pend;

   assign wr_ctl   = wr_en && (wr_addr == ADDR_CTL);
   assign wr_rate  = wr_en && (wr_addr == ADDR_RATE);
   assign wr_ccr   = wr_en && (wr_addr == ADDR_CCR);
   assign pulse_go = wr_rate && wr_data[RATE_PULSE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= 8'h00;
         rate_q <= 2'd0;
      end else begin
         if (wr_ctl) ctl_q <= wr_data;
         if (wr_rate || wr_ccr) rate_q <= wr_data[1:0];
      end
   end

   drvctl_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk(clk), .rst_n(rst_n), .start(pulse_go), .busy(pulse_busy));

   assign core_rst = !ctl_q[CTL_RUN] || pulse_busy;

   for (genvar gi = 0; gi < NUM_DRV; gi++) begin : g_motor
      assign motor_en[gi] = ctl_q[CTL_MOT_LSB + gi];
   end

   assign ctl_rdata = ctl_q;
   assign drv_sel   = ctl_q[1:0];
   assign rate_sel  = rate_q;

   drvctl_pollq #(.NUM_DRV(NUM_DRV)) u_pollq (
      .clk(clk), .rst_n(rst_n), .in_rst(core_rst), .poll_en(poll_en),
      .sense_ack(sense_ack), .pending(pend), .st0(sense_st0));

   drvctl_cfg #(.THR_W(THR_W), .SRT_W(SRT_W), .HUT_W(HUT_W), .HLT_W(HLT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .in_rst(core_rst),
      .cfg_load(cfg_load), .cfg_fifo_en_in(cfg_fifo_en_in), .cfg_thr_in(cfg_thr_in),
      .cfg_poll_in(cfg_poll_in), .cfg_iseek_in(cfg_iseek_in),
      .lock_load(lock_load), .lock_in(lock_in),
      .spec_load(spec_load), .spec_srt_in(spec_srt_in), .spec_hut_in(spec_hut_in),
      .spec_hlt_in(spec_hlt_in), .spec_nodma_in(spec_nodma_in),
      .fifo_en(fifo_en), .fifo_thr(fifo_thr), .poll_en(poll_en), .iseek_en(iseek_en),
      .lock_q(lock_q), .step_rate(step_rate), .unload_time(unload_time),
      .load_time(load_time), .non_dma(non_dma));

   assign irq     = pend && ctl_q[CTL_GATE] && !core_rst;
   assign dma_req = dma_req_in && ctl_q[CTL_GATE] && !core_rst;

   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (!irq && !dma_req));
   p_rate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_rate || wr_ccr) |=> $stable(rate_sel));
   p_level_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[CTL_RUN] |-> core_rst);
   p_ctl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> (ctl_rdata == $past(wr_data)));
endmodule

// File: tb/drvctl_reset_unit_bench.sv
module drvctl_reset_unit_bench;
   localparam int NDRV = 4;
   localparam int PCYC = 5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic wr_en = 0; logic [1:0] wr_addr = 0; logic [7:0] wr_data = 0;
   logic dma_req_in = 0, sense_ack = 0;
   logic cfg_load = 0, cfg_fifo_en_in = 0, cfg_poll_in = 0, cfg_iseek_in = 0;
   logic [3:0] cfg_thr_in = 0;
   logic lock_load = 0, lock_in = 0, spec_load = 0, spec_nodma_in = 0;
   logic [3:0] spec_srt_in = 0, spec_hut_in = 0;
   logic [6:0] spec_hlt_in = 0;

   logic [7:0] ctl_rdata, sense_st0;
   logic [NDRV-1:0] motor_en;
   logic [1:0] drv_sel, rate_sel;
   logic core_rst, dma_req, irq, fifo_en, poll_en, iseek_en, lock_q, non_dma;
   logic [3:0] fifo_thr, step_rate, unload_time;
   logic [6:0] load_time;

   drvctl_reset_unit #(.NUM_DRV(NDRV), .PULSE_CYC(PCYC)) u_drvctl_reset_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctl_rdata(ctl_rdata), .motor_en(motor_en), .drv_sel(drv_sel), .rate_sel(rate_sel),
      .core_rst(core_rst), .dma_req_in(dma_req_in), .dma_req(dma_req), .irq(irq),
      .sense_ack(sense_ack), .sense_st0(sense_st0),
      .cfg_load(cfg_load), .cfg_fifo_en_in(cfg_fifo_en_in), .cfg_thr_in(cfg_thr_in),
      .cfg_poll_in(cfg_poll_in), .cfg_iseek_in(cfg_iseek_in),
      .lock_load(lock_load), .lock_in(lock_in), .spec_load(spec_load),
      .spec_srt_in(spec_srt_in), .spec_hut_in(spec_hut_in), .spec_hlt_in(spec_hlt_in),
      .spec_nodma_in(spec_nodma_in), .fifo_en(fifo_en), .fifo_thr(fifo_thr),
      .poll_en(poll_en), .iseek_en(iseek_en), .lock_q(lock_q), .step_rate(step_rate),
      .unload_time(unload_time), .load_time(load_time), .non_dma(non_dma));

   int vectors = 0, miscompares = 0, cycles = 0;
   bit done = 0;

   // behavioural reference model
   int m_ctl, m_rate, m_left, m_qc, m_qd;
   bit m_prst, m_flag, m_fifo, m_poll, m_iseek, m_lock, m_nodma;
   int m_thr, m_srt, m_hut, m_hlt;
   int q_st[$];

   function automatic bit m_inrst();
      return (((m_ctl >> 2) & 1) == 0) || (m_left > 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 0; m_rate = 0; m_left = 0; m_prst = 1; m_flag = 0;
         q_st.delete();
         m_fifo = 0; m_thr = 0; m_poll = 1; m_iseek = 0; m_lock = 0;
         m_srt = 0; m_hut = 0; m_hlt = 0; m_nodma = 0;
      end else begin
         bit r;
         r = m_inrst();
         if (r) begin
            q_st.delete(); m_flag = 0;
            if (!m_lock) begin m_fifo = 0; m_thr = 0; end
            m_srt = 0; m_hut = 0; m_hlt = 0; m_nodma = 0;
         end else begin
            if (m_prst) begin
               if (m_poll) for (int d = 0; d < NDRV; d++) q_st.push_back(8'hC0 | d);
               else m_flag = 1;
            end else if (sense_ack) begin
               m_flag = 0;
               if (q_st.size() > 0) void'(q_st.pop_front());
            end
            if (cfg_load) begin
               m_fifo = cfg_fifo_en_in; m_thr = cfg_thr_in;
               m_poll = cfg_poll_in; m_iseek = cfg_iseek_in;
            end
            if (lock_load) m_lock = lock_in;
            if (spec_load) begin
               m_srt = spec_srt_in; m_hut = spec_hut_in;
               m_hlt = spec_hlt_in; m_nodma = spec_nodma_in;
            end
         end
         m_prst = r;
         if (wr_en && wr_addr == 1 && wr_data[7]) m_left = PCYC;
         else if (m_left > 0) m_left--;
         if (wr_en && wr_addr == 0) m_ctl = wr_data;
         if (wr_en && (wr_addr == 1 || wr_addr == 2)) m_rate = wr_data[1:0];
      end
   end

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit r, g, p;
         r = m_inrst();
         g = ((m_ctl >> 3) & 1) != 0;
         p = (q_st.size() > 0) || m_flag;
         chk("R1 ctl_rdata", ctl_rdata, m_ctl);
         chk("R1 motor_en", motor_en, (m_ctl >> 4) & 4'hF);
         chk("R1 drv_sel", drv_sel, m_ctl & 3);
         chk("R2/R3 core_rst", core_rst, r);
         chk("R4 rate_sel", rate_sel, m_rate);
         chk("R5/R6 sense_st0", sense_st0, (q_st.size() > 0) ? q_st[0] : 8'h80);
         chk("R7 irq", irq, p && g && !r);
         chk("R7 dma_req", dma_req, dma_req_in && g && !r);
         chk("R8 fifo_en", fifo_en, m_fifo);
         chk("R8 fifo_thr", fifo_thr, m_thr);
         chk("R8 poll_en", poll_en, m_poll);
         chk("R8 iseek_en", iseek_en, m_iseek);
         chk("R10 lock_q", lock_q, m_lock);
         chk("R9 step_rate", step_rate, m_srt);
         chk("R9 unload_time", unload_time, m_hut);
         chk("R9 load_time", load_time, m_hlt);
         chk("R9 non_dma", non_dma, m_nodma);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
      wr_en = 0; sense_ack = 0; cfg_load = 0; lock_load = 0; spec_load = 0;
   endtask
   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask
   task automatic wr(logic [1:0] a, logic [7:0] d);
      tick(); wr_en = 1; wr_addr = a; wr_data = d;
   endtask
   task automatic cfg(bit f, logic [3:0] t, bit p, bit s);
      tick(); cfg_load = 1; cfg_fifo_en_in = f; cfg_thr_in = t;
      cfg_poll_in = p; cfg_iseek_in = s;
   endtask
   task automatic spec(logic [3:0] s, logic [3:0] h, logic [6:0] l, bit n);
      tick(); spec_load = 1; spec_srt_in = s; spec_hut_in = h;
      spec_hlt_in = l; spec_nodma_in = n;
   endtask
   task automatic lock(bit v);
      tick(); lock_load = 1; lock_in = v;
   endtask
   task automatic sense();
      tick(); sense_ack = 1;
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(3);
      // R10: loads while in reset (ctl bit2 clear) are ignored
      cfg(1, 4'd9, 0, 1); lock(1); spec(4'd3, 4'd2, 7'd5, 1); sense();
      idle(2);
      // R1/R2: leave level reset with gate set, drive 2 selected
      wr(0, 8'h1E);
      idle(3);
      // R5: pop the four entries, with gaps
      for (int k = 0; k < 5; k++) begin sense(); idle(1); end
      // configuration and timing values
      cfg(1, 4'd8, 1, 1); spec(4'd11, 4'd15, 7'd100, 1);
      dma_req_in = 1; idle(2);
      // R4: config-control register write, unused address
      wr(2, 8'h03); idle(1); wr(3, 8'h02); idle(1);
      // R3: self-timed pulse, unlocked clears fifo
      wr(1, 8'h81); idle(PCYC + 4);
      for (int k = 0; k < 2; k++) sense();
      // R8: lock, then level reset keeps fifo settings
      cfg(1, 4'd12, 1, 0); lock(1); spec(4'd1, 4'd1, 7'd1, 0);
      wr(0, 8'h18); idle(4); wr(0, 8'h1C); idle(3);
      // R7: masked interrupt, entries stay queued
      wr(0, 8'hF0); idle(2); wr(0, 8'hF5); idle(4);
      wr(0, 8'hFD); idle(2);
      for (int k = 0; k < 4; k++) sense();
      dma_req_in = 0; idle(2);
      // R6: polling off, single flag
      cfg(0, 4'd2, 0, 1); wr(1, 8'h80); idle(PCYC + 3);
      sense(); idle(3);
      // R3: pulse restarted while running
      wr(1, 8'h82); idle(2); wr(1, 8'h83); idle(PCYC + 3);
      wr(0, 8'h2B); idle(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule